// File: doc/BRIEF.md
# Ring Latency Timer and Interrupt Unit

This unit sits beside a token-ring MAC. It times the ring latency and counts tokens, and it reports what happens through a small sticky event register, a mask register and one registered interrupt line. A start strobe clears the latency timer and arms it. A stop strobe ends the timing. If the timer never wrapped, the elapsed count is copied into a result register and a "fresh result" event is raised. If the timer wrapped during the run, a timer-wrap event is raised instead and the old result is kept. A separate 16-bit counter advances on every token-seen strobe. When it wraps to zero it raises its own event and keeps counting.

The latency timer is controlled by a three-state machine. Its states are `VT_IDLE` (not timing), `VT_RUN` (timing, no wrap yet) and `VT_WRAP` (timing, the count has wrapped at least once). The transitions are as follows. The `arm` transition goes from any state to `VT_RUN` on a start strobe, and start has priority over everything else. The `finish` transition goes from `VT_RUN` to `VT_IDLE` on stop and loads the result. The `wrap` transition goes from `VT_RUN` to `VT_WRAP` when the count steps past all-ones. The `abandon` transition goes from `VT_WRAP` to `VT_IDLE` on stop and loads nothing. The `rewrap` transition goes from `VT_WRAP` back to itself on each further wrap. A stop in `VT_IDLE` is ignored.

A host reaches four registers through a simple port: write strobe, 2-bit address, write data, and combinational read data. There are two resets. The power-up reset is asynchronous and active low. The MAC reset is synchronous and active high, and it clears everything except the mask register.

Top module: `ring_latency_irq`

## Requirements
- R1: While `por_n` is low, the latency result, the token count, the event bits, the mask and `irq` are all zero. A cycle with `mac_rst` high clears the result, the count, the event bits, `irq` and the timer state, but leaves the mask unchanged.
- R2: A start strobe sampled at clock edge S, followed by a stop strobe sampled at edge S+k (k≥1) with no wrap in between, loads `latency_q` with k−1 at edge S+k. In that same edge it sets event bit 2, the ready bit.
- R3: When the latency count steps past 16'hFFFF it wraps to zero and sets event bit 1, and timing continues. A later stop then leaves `latency_q` unchanged and does not set bit 2.
- R4: `token_count` increases by one on each edge where `token_seen` is sampled high. Stepping past 16'hFFFF wraps it to zero and sets event bit 0.
- R5: Event bits stay set until the host writes address 0 with a 1 in the matching bit position of `host_wdata[2:0]`. If an event arrives in the same cycle as its clear, the bit stays set.
- R6: A write to address 1 stores `host_wdata[2:0]` in the mask. Bits 15..3 of that write are dropped. The host may write the mask at any time.
- R7: `irq` is registered. After each edge it equals the OR of (event AND mask) as those registers stood before that edge. It therefore falls one cycle after the last matching event bit is cleared or masked.
- R8: `host_rdata` is selected by `host_addr`. Address 0 gives the event bits in bits 2..0, address 1 gives the mask, address 2 gives `latency_q` and address 3 gives `token_count`. All unused bits read as zero.
- R9: A stop with no timing in progress has no effect. A start during timing restarts it from zero. When start and stop arrive in the same cycle, start wins and no result is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-up reset, asynchronous, active low |
| mac_rst | input | 1 | MAC reset, synchronous, active high; mask unaffected |
| meas_start | input | 1 | Start strobe: clear the timer and begin timing |
| meas_stop | input | 1 | Stop strobe: end timing |
| token_seen | input | 1 | One pulse per token observed |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | 2 | Host register select |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data for `host_addr` |
| latency_q | output | 16 | Last valid latency result |
| token_count | output | 16 | Token count |
| event_flags | output | 3 | Sticky events: [2] ready, [1] timer wrap, [0] token wrap |
| irq | output | 1 | Registered interrupt request |

## Verification
Two pairs of events can land in the same cycle. The first pair is an event being raised while the host clears it. The bench provokes this by putting a stop strobe that completes a measurement on the same edge as a write of 1 to the ready bit, and it expects the bit to stay set. The second pair is the two wrap events. The bench starts a measurement one cycle before it begins strobing `token_seen` every cycle, which makes the latency timer and the token counter pass 16'hFFFF on the same edge. It then expects both wrap bits to appear together, expects the later stop to leave the result alone, and compares everything against a behavioural model on every clock.

// File: rtl/rli_pkg.sv
package rli_pkg;

    typedef enum logic [1:0] {
        VT_IDLE = 2'd0,
        VT_RUN  = 2'd1,
        VT_WRAP = 2'd2
    } vt_state_e;

    localparam int NUM_EV   = 3;
    localparam int EV_READY = 2;
    localparam int EV_TWRAP = 1;
    localparam int EV_KWRAP = 0;

    localparam logic [1:0] A_EVENT = 2'd0;
    localparam logic [1:0] A_MASK  = 2'd1;
    localparam logic [1:0] A_LAT   = 2'd2;
    localparam logic [1:0] A_TOKEN = 2'd3;

endpackage

// File: rtl/void_timer.sv
module void_timer
    import rli_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         por_n,
    input  logic         mac_rst,
    input  logic         start,
    input  logic         stop,
    output logic [W-1:0] lat_q,
    output logic         ready_pulse,
    output logic         wrap_pulse
);

    localparam logic [W-1:0] CNT_TOP = {W{1'b1}};

    vt_state_e    state_q, state_d;
    logic [W-1:0] cnt_q;
    logic         at_top;

    assign at_top = (cnt_q == CNT_TOP);

    // state register
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            state_q <= VT_IDLE;
        end else if (mac_rst) begin
            state_q <= VT_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: arm, finish, wrap, abandon, rewrap
    always_comb begin
        state_d = state_q;
        if (start) begin
            state_d = VT_RUN;
        end else begin
            unique case (state_q)
                VT_IDLE: state_d = VT_IDLE;
                VT_RUN: begin
                    if (stop)        state_d = VT_IDLE;
                    else if (at_top) state_d = VT_WRAP;
                end
                VT_WRAP: begin
                    if (stop) state_d = VT_IDLE;
                end
                default: state_d = VT_IDLE;
            endcase
        end
    end

    // output strobes
    always_comb begin
        ready_pulse = 1'b0;
        wrap_pulse  = 1'b0;
        if (!start) begin
            unique case (state_q)
                VT_IDLE: ;
                VT_RUN: begin
                    ready_pulse = stop;
                    wrap_pulse  = !stop && at_top;
                end
                VT_WRAP: wrap_pulse = !stop && at_top;
                default: ;
            endcase
        end
    end

    // counter and result register
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            cnt_q <= '0;
            lat_q <= '0;
        end else if (mac_rst) begin
            cnt_q <= '0;
            lat_q <= '0;
        end else begin
            if (start) begin
                cnt_q <= '0;
            end else if (state_q != VT_IDLE && !stop) begin
                cnt_q <= cnt_q + 1'b1;
            end
            if (ready_pulse) begin
                lat_q <= cnt_q;
            end
        end
    end

endmodule

// File: rtl/token_counter.sv
module token_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         por_n,
    input  logic         mac_rst,
    input  logic         tick,
    output logic [W-1:0] count,
    output logic         wrap_pulse
);

    localparam logic [W-1:0] CNT_TOP = {W{1'b1}};

    assign wrap_pulse = tick && (count == CNT_TOP);

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            count <= '0;
        end else if (mac_rst) begin
            count <= '0;
        end else if (tick) begin
            count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/evt_mask_unit.sv
module evt_mask_unit #(
    parameter int NEV = 3
) (
    input  logic           clk,
    input  logic           por_n,
    input  logic           mac_rst,
    input  logic [NEV-1:0] set_vec,
    input  logic [NEV-1:0] clr_vec,
    input  logic           mask_wr,
    input  logic [NEV-1:0] mask_wdata,
    output logic [NEV-1:0] ev_q,
    output logic [NEV-1:0] mask_q,
    output logic           irq_q
);

    genvar gi;
    generate
        for (gi = 0; gi < NEV; gi++) begin : g_ev
            always_ff @(posedge clk or negedge por_n) begin
                if (!por_n) begin
                    ev_q[gi] <= 1'b0;
                end else if (mac_rst) begin
                    ev_q[gi] <= 1'b0;
                end else if (set_vec[gi]) begin
                    ev_q[gi] <= 1'b1;
                end else if (clr_vec[gi]) begin
                    ev_q[gi] <= 1'b0;
                end
            end
        end
    endgenerate

    // mask answers only to power-up reset
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            mask_q <= '0;
        end else if (mask_wr) begin
            mask_q <= mask_wdata;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            irq_q <= 1'b0;
        end else if (mac_rst) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= |(ev_q & mask_q);
        end
    end

endmodule

// File: rtl/ring_latency_irq.sv
module ring_latency_irq
    import rli_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              mac_rst,
    input  logic              meas_start,
    input  logic              meas_stop,
    input  logic              token_seen,
    input  logic              host_wr,
    input  logic [1:0]        host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic [CNT_W-1:0]  latency_q,
    output logic [CNT_W-1:0]  token_count,
    output logic [NUM_EV-1:0] event_flags,
    output logic              irq
);

    logic              rdy_p, twrap_p, kwrap_p;
    logic [NUM_EV-1:0] set_vec, clr_vec;
    logic              mask_wr;
    logic [NUM_EV-1:0] mask_q;

    void_timer #(.W(CNT_W)) u_timer (
        .clk        (clk),
        .por_n      (por_n),
        .mac_rst    (mac_rst),
        .start      (meas_start),
        .stop       (meas_stop),
        .lat_q      (latency_q),
        .ready_pulse(rdy_p),
        .wrap_pulse (twrap_p)
    );

    token_counter #(.W(CNT_W)) u_tok (
        .clk       (clk),
        .por_n     (por_n),
        .mac_rst   (mac_rst),
        .tick      (token_seen),
        .count     (token_count),
        .wrap_pulse(kwrap_p)
    );

    always_comb begin
        set_vec           = '0;
        set_vec[EV_READY] = rdy_p;
        set_vec[EV_TWRAP] = twrap_p;
        set_vec[EV_KWRAP] = kwrap_p;
    end

    assign clr_vec = (host_wr && host_addr == A_EVENT) ? host_wdata[NUM_EV-1:0] : '0;
    assign mask_wr = host_wr && (host_addr == A_MASK);

    evt_mask_unit #(.NEV(NUM_EV)) u_evt (
        .clk       (clk),
        .por_n     (por_n),
        .mac_rst   (mac_rst),
        .set_vec   (set_vec),
        .clr_vec   (clr_vec),
        .mask_wr   (mask_wr),
        .mask_wdata(host_wdata[NUM_EV-1:0]),
        .ev_q      (event_flags),
        .mask_q    (mask_q),
        .irq_q     (irq)
    );

    always_comb begin
        host_rdata = '0;
        unique case (host_addr)
            A_EVENT: host_rdata[NUM_EV-1:0] = event_flags;
            A_MASK:  host_rdata[NUM_EV-1:0] = mask_q;
            A_LAT:   host_rdata[CNT_W-1:0]  = latency_q;
            A_TOKEN: host_rdata[CNT_W-1:0]  = token_count;
            default: host_rdata = '0;
        endcase
    end

endmodule

// File: rtl/rli_checker.sv
module rli_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             por_n,
    input logic             mac_rst,
    input logic             host_wr,
    input logic             token_seen,
    input logic [CNT_W-1:0] latency_q,
    input logic [CNT_W-1:0] token_count,
    input logic [2:0]       event_flags,
    input logic [2:0]       mask_q,
    input logic             irq
);

    assert_irq_follows_R7: assert property (@(posedge clk) disable iff (!por_n)
        !$past(mac_rst) |-> (irq == $past(|(event_flags & mask_q))));

    assert_token_wrap_R4: assert property (@(posedge clk) disable iff (!por_n)
        (!$past(mac_rst) && $past(token_seen) && $past(token_count) == {CNT_W{1'b1}})
        |-> (event_flags[0] && token_count == '0));

    assert_token_hold_R4: assert property (@(posedge clk) disable iff (!por_n)
        (!$past(mac_rst) && !$past(token_seen)) |-> $stable(token_count));

    assert_latency_only_with_ready_R2: assert property (@(posedge clk) disable iff (!por_n)
        (!$past(mac_rst) && latency_q != $past(latency_q)) |-> event_flags[2]);

    assert_mask_survives_mac_rst_R1: assert property (@(posedge clk) disable iff (!por_n)
        ($past(mac_rst) && !$past(host_wr)) |-> $stable(mask_q));

endmodule

bind ring_latency_irq rli_checker #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .por_n      (por_n),
    .mac_rst    (mac_rst),
    .host_wr    (host_wr),
    .token_seen (token_seen),
    .latency_q  (latency_q),
    .token_count(token_count),
    .event_flags(event_flags),
    .mask_q     (mask_q),
    .irq        (irq)
);

// File: tb/ring_latency_irq_bench.sv
`timescale 1ns/1ps
module ring_latency_irq_bench;

    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        mac_rst = 1'b0;
    logic        meas_start = 1'b0;
    logic        meas_stop = 1'b0;
    logic        token_seen = 1'b0;
    logic        host_wr = 1'b0;
    logic [1:0]  host_addr = 2'd0;
    logic [15:0] host_wdata = 16'd0;
    logic [15:0] host_rdata;
    logic [15:0] latency_q;
    logic [15:0] token_count;
    logic [2:0]  event_flags;
    logic        irq;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    ring_latency_irq u_ring_latency_irq (
        .clk        (clk),
        .por_n      (por_n),
        .mac_rst    (mac_rst),
        .meas_start (meas_start),
        .meas_stop  (meas_stop),
        .token_seen (token_seen),
        .host_wr    (host_wr),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .latency_q  (latency_q),
        .token_count(token_count),
        .event_flags(event_flags),
        .irq        (irq)
    );

    // behavioural reference: 0 idle, 1 timing, 2 timing after wrap
    int m_mode = 0, m_cnt = 0, m_lat = 0, m_tok = 0, m_ev = 0, m_mask = 0, m_irq = 0;

    always @(posedge clk or negedge por_n) begin
        int clr, set, irq_next;
        if (!por_n) begin
            m_mode = 0; m_cnt = 0; m_lat = 0; m_tok = 0; m_ev = 0; m_mask = 0; m_irq = 0;
        end else begin
            clr = (host_wr && host_addr == 2'd0) ? int'(host_wdata[2:0]) : 0;
            set = 0;
            irq_next = ((m_ev & m_mask) != 0) ? 1 : 0;
            if (mac_rst) begin
                m_mode = 0; m_cnt = 0; m_lat = 0; m_tok = 0; m_ev = 0; m_irq = 0;
            end else begin
                if (meas_start) begin
                    m_mode = 1; m_cnt = 0;
                end else if (m_mode != 0) begin
                    if (meas_stop) begin
                        if (m_mode == 1) begin m_lat = m_cnt; set = set | 4; end
                        m_mode = 0;
                    end else if (m_cnt == 65535) begin
                        m_cnt = 0; m_mode = 2; set = set | 2;
                    end else begin
                        m_cnt = m_cnt + 1;
                    end
                end
                if (token_seen) begin
                    if (m_tok == 65535) set = set | 1;
                    m_tok = (m_tok + 1) % 65536;
                end
                m_ev = (m_ev & ~clr & 7) | set;
                m_irq = irq_next;
            end
            if (host_wr && host_addr == 2'd1) m_mask = int'(host_wdata[2:0]);
        end
    end

    task automatic check(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got 0x%0h expected 0x%0h at %0t", tag, got, exp, $time);
        end
    endtask

    // compare against the model on every clock
    always @(negedge clk) begin
        if (por_n) begin
            check("R2 latency vs model", int'(latency_q), m_lat);
            check("R4 token count vs model", int'(token_count), m_tok);
            check("R5 events vs model", int'(event_flags), m_ev);
            check("R7 irq vs model", int'(irq), m_irq);
        end
    end

    task automatic host_write(input logic [1:0] a, input logic [15:0] d);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0; host_wdata = 16'd0;
    endtask

    task automatic host_read_check(input string tag, input logic [1:0] a, input int exp);
        host_addr = a;
        #1;
        check(tag, int'(host_rdata), exp);
    endtask

    task automatic pulse_start();
        meas_start = 1'b1; @(negedge clk); meas_start = 1'b0;
    endtask

    task automatic pulse_stop();
        meas_stop = 1'b1; @(negedge clk); meas_stop = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 power-up state
        check("R1 latency after por", int'(latency_q), 0);
        check("R1 events after por", int'(event_flags), 0);
        check("R1 irq after por", int'(irq), 0);
        host_read_check("R1 mask after por", 2'd1, 0);
        por_n = 1'b1;
        @(negedge clk);

        // R6 mask write drops upper bits; R8 read map
        host_write(2'd1, 16'hFFFF);
        host_read_check("R6 mask readback", 2'd1, 7);

        // R2 latency of 9
        pulse_start();
        repeat (9) @(negedge clk);
        pulse_stop();
        check("R2 latency value", int'(latency_q), 9);
        check("R2 ready bit", int'(event_flags), 4);
        host_read_check("R8 latency read", 2'd2, 9);
        check("R7 irq not yet", int'(irq), 0);
        @(negedge clk);
        check("R7 irq raised", int'(irq), 1);

        // R5 W1C, R7 irq falls one cycle later
        host_write(2'd0, 16'h0004);
        check("R5 cleared", int'(event_flags), 0);
        check("R7 irq lags clear", int'(irq), 1);
        @(negedge clk);
        check("R7 irq fallen", int'(irq), 0);

        // R9 start and stop together: start wins
        meas_start = 1'b1; meas_stop = 1'b1;
        @(negedge clk);
        meas_start = 1'b0; meas_stop = 1'b0;
        check("R9 no ready on start+stop", int'(event_flags), 0);
        check("R9 latency kept", int'(latency_q), 9);
        repeat (4) @(negedge clk);
        pulse_stop();
        check("R9 restarted latency", int'(latency_q), 4);

        // R9 stop while idle ignored
        host_write(2'd0, 16'h0007);
        pulse_stop();
        check("R9 idle stop latency", int'(latency_q), 4);
        check("R9 idle stop events", int'(event_flags), 0);

        // R9 restart during timing
        pulse_start();
        repeat (6) @(negedge clk);
        pulse_start();
        repeat (2) @(negedge clk);
        pulse_stop();
        check("R9 restart latency", int'(latency_q), 2);

        // R5 set wins over clear in the same cycle
        pulse_start();
        repeat (2) @(negedge clk);
        meas_stop = 1'b1; host_wr = 1'b1; host_addr = 2'd0; host_wdata = 16'h0004;
        @(negedge clk);
        meas_stop = 1'b0; host_wr = 1'b0; host_wdata = 16'd0;
        check("R5 set wins", int'(event_flags), 4);

        // R1 MAC reset keeps mask
        host_write(2'd1, 16'h0005);
        token_seen = 1'b1;
        repeat (3) @(negedge clk);
        token_seen = 1'b0;
        host_read_check("R8 token read", 2'd3, 3);
        mac_rst = 1'b1;
        @(negedge clk);
        mac_rst = 1'b0;
        host_read_check("R1 mask kept", 2'd1, 5);
        check("R1 events cleared", int'(event_flags), 0);
        check("R1 latency cleared", int'(latency_q), 0);
        check("R1 token cleared", int'(token_count), 0);
        check("R1 irq cleared", int'(irq), 0);

        // R3 and R4: both counters wrap on the same edge
        host_write(2'd1, 16'h0003);
        pulse_start();
        token_seen = 1'b1;
        repeat (65535) @(negedge clk);
        check("R4 token at top", int'(token_count), 65535);
        check("R3 no wrap yet", int'(event_flags), 0);
        @(negedge clk);
        token_seen = 1'b0;
        check("R3 R4 both wraps", int'(event_flags), 3);
        check("R4 token wrapped", int'(token_count), 0);
        host_read_check("R8 event read reserved zero", 2'd0, 3);
        repeat (5) @(negedge clk);
        pulse_stop();
        check("R3 latency not loaded", int'(latency_q), 0);
        check("R3 no ready", int'(event_flags), 3);
        check("R7 irq masked wraps", int'(irq), 1);
        host_write(2'd1, 16'h0004);
        @(negedge clk);
        check("R7 irq after mask", int'(irq), 0);

        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule